// File: doc/BRIEF.md
# MDIO Management Register Master

This block gives a processor register-level access to the management registers of an external Ethernet PHY over the two-wire MDIO bus. Software writes a single 32-bit command word that carries the write data, the 5-bit PHY address, the 5-bit register address and an operation bit. The block then produces the MDC clock from the system clock and serialises one clause-22 frame onto MDIO. For a read, it releases the line at turnaround and shifts in the PHY's reply.

The same word reads back as status. It shows a busy flag for the length of the frame, and the read result in the upper half-word where the write data was held. A not-valid flag is raised when no PHY drove the line low in the turnaround slot. Software polls busy, then reads the result. A command written while busy is dropped.

Top module: `mdio_master`

## Requirements
- R1: After reset the status word reads the PHY address field [15:11] as parameter PHY_ADDR_RST and every other bit as 0. MDC is low and MDIO is not driven.
- R2: An accepted command word loads data [31:16], PHY address [15:11] and register address [10:6]. Bit 1 set starts a read, and a read wins when both bits are set. Bit 0 alone starts a write. With neither bit set, only the fields load and no frame starts.
- R3: The busy flag (status bit 3) rises on the clock edge that accepts a start. It stays high for exactly 128*MDC_HALF clock cycles, which is 64 MDC periods.
- R4: MDC has a period of 2*MDC_HALF clock cycles while busy, and stays low while idle.
- R5: A write frame, as seen at MDC rising edges and MSB first, is 32 ones, 01, 01, PHY address, register address, 10, then 16 data bits. MDIO is driven for all 64 bits.
- R6: A read frame drives 32 ones, 01, 10, PHY address and register address (46 bits). It releases MDIO for the remaining 18 bits.
- R7: When a read completes, the 16 bits sampled after turnaround (MSB first) appear in status [31:16]. A write leaves [31:16] at the written data. The field does not change while busy.
- R8: The not-valid flag (status bit 4) is set at the end of a read if MDIO was high at the MDC rising edge of the second turnaround bit. Otherwise it is cleared. Any accepted start clears it.
- R9: A command word written while busy is ignored. The fields and the frame in flight are unchanged.
- R10: MDIO data and its output enable change only on MDC falling edges, or on the edge that accepts a start. They are stable across every MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 32 | Command word write value |
| status_o | output | 32 | Command/status word readback |
| mdc_o | output | 1 | Management clock to PHY |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input (pulled high when undriven) |

## Verification
The assertions check four things on every cycle: MDC stays low and the line stays released whenever busy is low, the data and enable lines are stable at each MDC rise, the half-word stays frozen during a frame, and a start always clears not-valid. The bench scenarios cover the rest: bit-exact frame contents for both operations, the read result and not-valid outcome with a PHY present or absent, read priority when both operation bits are set, the exact busy length and MDC period, and a command dropped mid-frame.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  typedef logic [IDX_W-1:0] bit_idx_t;

  localparam bit_idx_t LAST_IDX    = bit_idx_t'(FRAME_BITS - 1);
  localparam bit_idx_t RELEASE_IDX = bit_idx_t'(46);
  localparam bit_idx_t TA2_IDX     = bit_idx_t'(47);
  localparam bit_idx_t DATA_IDX    = bit_idx_t'(48);

  localparam int unsigned WR_BIT     = 0;
  localparam int unsigned RD_BIT     = 1;
  localparam int unsigned BUSY_BIT   = 3;
  localparam int unsigned NVALID_BIT = 4;

  typedef struct packed {
    logic [15:0] data;
    logic [4:0]  phy;
    logic [4:0]  regad;
  } mdio_cmd_t;

  typedef enum logic {ST_IDLE, ST_RUN} mdio_state_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c, logic rd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), c.phy, c.regad,
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : c.data)};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int unsigned HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // edge strobes: the MDC transition takes effect at this clock edge
  assign rise_o = en_i && wrap && !mdc_q;
  assign fall_o = en_i && wrap &&  mdc_q;
  assign mdc_o  = mdc_q;
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rd_i,
  input  mdio_cmd_t   cmd_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        run_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        done_rd_o,
  output logic [15:0] rd_data_o,
  output logic        nvalid_o
);
  mdio_state_e           state_q;
  logic                  is_rd_q;
  bit_idx_t              idx_q;
  logic [FRAME_BITS-1:0] shreg_q;
  logic [15:0]           rdata_q;
  logic                  nv_q;
  logic                  last_fall;

  assign last_fall = (state_q == ST_RUN) && fall_i && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      is_rd_q <= 1'b0;
      idx_q   <= '0;
      shreg_q <= '0;
      rdata_q <= '0;
      nv_q    <= 1'b0;
    end else if (start_i && state_q == ST_IDLE) begin
      state_q <= ST_RUN;
      is_rd_q <= rd_i;
      idx_q   <= '0;
      shreg_q <= build_frame(cmd_i, rd_i);
      nv_q    <= 1'b0;
    end else if (state_q == ST_RUN) begin
      if (rise_i && is_rd_q) begin
        if (idx_q == TA2_IDX) nv_q <= mdio_i;  // PHY must pull low here
        if (idx_q >= DATA_IDX) rdata_q <= {rdata_q[14:0], mdio_i};
      end
      if (fall_i) begin
        if (idx_q == LAST_IDX) begin
          state_q <= ST_IDLE;
        end else begin
          idx_q   <= idx_q + 1'b1;
          shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  assign run_o     = (state_q == ST_RUN);
  assign mdio_o    = shreg_q[FRAME_BITS-1];
  assign mdio_oe_o = (state_q == ST_RUN) && (!is_rd_q || idx_q < RELEASE_IDX);
  assign done_rd_o = last_fall && is_rd_q;
  assign rd_data_o = rdata_q;
  assign nvalid_o  = nv_q;
endmodule

// File: rtl/mdio_cmd_reg.sv
`timescale 1ns/1ps
module mdio_cmd_reg
  import mdio_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR_RST = 5'd3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic        busy_i,
  input  logic        done_rd_i,
  input  logic [15:0] rd_data_i,
  input  logic        nvalid_i,
  output logic        start_o,
  output logic        start_rd_o,
  output mdio_cmd_t   cmd_o,
  output logic [31:0] status_o
);
  mdio_cmd_t cmd_q;
  logic      nv_q;
  logic      accept;
  logic      unused_bits;

  assign unused_bits = ^wdata_i[5:2];
  assign accept      = we_i && !busy_i;
  assign start_o     = accept && (wdata_i[RD_BIT] || wdata_i[WR_BIT]);
  assign start_rd_o  = wdata_i[RD_BIT];
  assign cmd_o       = mdio_cmd_t'(wdata_i[31:6]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '{data: 16'h0, phy: PHY_ADDR_RST, regad: 5'h0};
      nv_q  <= 1'b0;
    end else if (accept) begin
      cmd_q <= cmd_o;
      if (start_o) nv_q <= 1'b0;
    end else if (done_rd_i) begin
      cmd_q.data <= rd_data_i;
      nv_q       <= nvalid_i;
    end
  end

  assign status_o = {cmd_q, 1'b0, nv_q, busy_i, 3'b000};
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned MDC_HALF     = 4,
  parameter logic [4:0]  PHY_ADDR_RST = 5'd3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  output logic [31:0] status_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic        run, rise, fall, start, start_rd, done_rd, nvalid;
  logic [15:0] rd_data;
  mdio_cmd_t   cmd;

  mdio_cmd_reg #(.PHY_ADDR_RST(PHY_ADDR_RST)) u_cmd (
    .clk_i, .rst_ni,
    .we_i(cmd_we_i), .wdata_i(cmd_wdata_i), .busy_i(run),
    .done_rd_i(done_rd), .rd_data_i(rd_data), .nvalid_i(nvalid),
    .start_o(start), .start_rd_o(start_rd), .cmd_o(cmd), .status_o(status_o)
  );

  mdio_clk_div #(.HALF(MDC_HALF)) u_div (
    .clk_i, .rst_ni, .en_i(run), .mdc_o(mdc_o), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .rd_i(start_rd), .cmd_i(cmd),
    .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i),
    .run_o(run), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
    .done_rd_o(done_rd), .rd_data_o(rd_data), .nvalid_o(nvalid)
  );
endmodule

// File: rtl/mdio_master_sva.sv
`timescale 1ns/1ps
module mdio_master_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_we_i,
  input logic [31:0] status_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  assert_mdc_idle_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[3] |-> !mdc_o);

  assert_released_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[3] |-> !mdio_oe_o);

  assert_data_stable_at_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  assert_busy_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && status_o[3]) |=> $stable(status_o[15:6]));

  assert_data_frozen_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] && $past(status_o[3])) |-> $stable(status_o[31:16]));

  assert_start_clears_nvalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[3]) |-> !status_o[4]);
endmodule

bind mdio_master mdio_master_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_we_i(cmd_we_i), .status_o(status_o),
  .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
);

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  localparam int unsigned HALF = 4;
  localparam logic [4:0] PRST = 5'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] status;
  logic        mdc, mdio_out, mdio_oe, mdio_in;

  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;

  int   rise_cnt = 0;
  logic cap_bit [64];
  logic cap_oe  [64];
  realtime rise_t [64];

  logic        phy_on = 1'b0;
  logic [15:0] phy_val = '0;

  always #2 clk = ~clk;

  mdio_master #(.MDC_HALF(HALF), .PHY_ADDR_RST(PRST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(we), .cmd_wdata_i(wdata),
    .status_o(status), .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe),
    .mdio_i(mdio_in)
  );

  // PHY model: pulled high unless someone drives; answers reads when present
  function automatic logic phy_drive(int k);
    if (k == 47) return 1'b0;
    return phy_val[63-k];
  endfunction

  assign mdio_in = mdio_oe ? mdio_out :
                   (phy_on && !mdio_oe && rise_cnt >= 47 && rise_cnt <= 63) ? phy_drive(rise_cnt) : 1'b1;

  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      cap_bit[rise_cnt] = mdio_out;
      cap_oe[rise_cnt]  = mdio_oe;
      rise_t[rise_cnt]  = $realtime;
    end
    rise_cnt = rise_cnt + 1;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd_word(logic [15:0] d, logic [4:0] p, logic [4:0] r, logic [1:0] op);
    return {d, p, r, 4'b0, op};
  endfunction

  task automatic issue(logic [31:0] w);
    rise_cnt = 0;
    @(negedge clk); we = 1'b1; wdata = w;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_idle(output int busy_cycles);
    busy_cycles = 0;
    while (status[3] && busy_cycles < 100000) begin
      busy_cycles++;
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] cap_word();
    logic [63:0] v;
    for (int i = 0; i < 64; i++) v[63-i] = cap_bit[i];
    return v;
  endfunction

  function automatic logic [63:0] oe_word();
    logic [63:0] v;
    for (int i = 0; i < 64; i++) v[63-i] = cap_oe[i];
    return v;
  endfunction

  task automatic t_reset();
    chk("R1 status", {32'h0, status}, {32'h0, 16'h0, PRST, 11'h0});
    chk("R1 mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  task automatic t_write();
    int bc;
    issue(cmd_word(16'hA5C3, 5'd17, 5'd9, 2'b01));
    chk("R3 busy after accept", {63'h0, status[3]}, 64'h1);
    wait_idle(bc);
    chk("R3 busy length", 64'(bc), 64'(128*HALF));
    chk("R5 write frame", cap_word(), {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd17, 5'd9, 2'b10, 16'hA5C3});
    chk("R5 write oe", oe_word(), {64{1'b1}});
    chk("R4 mdc period", 64'(int'((rise_t[1]-rise_t[0])/1ns)), 64'(8*HALF));
    chk("R4 rise count", 64'(rise_cnt), 64'd64);
    chk("R7 write data kept", {32'h0, status}, {32'h0, 16'hA5C3, 5'd17, 5'd9, 6'h0});
  endtask

  task automatic t_read_present();
    int bc;
    phy_on = 1'b1; phy_val = 16'h796D;
    issue(cmd_word(16'h1111, 5'd31, 5'd31, 2'b10));
    wait_idle(bc);
    chk("R6 read drive bits", {18'h0, cap_word()[63:18]},
        {18'h0, 32'hFFFF_FFFF, 2'b01, 2'b10, 5'd31, 5'd31});
    chk("R6 read oe", oe_word(), {{46{1'b1}}, 18'h0});
    chk("R7 read data", {32'h0, status}, {32'h0, 16'h796D, 5'd31, 5'd31, 6'h0});
    chk("R8 nvalid clear", {63'h0, status[4]}, 64'h0);
  endtask

  task automatic t_read_absent();
    int bc;
    phy_on = 1'b0;
    issue(cmd_word(16'h0, 5'd0, 5'd2, 2'b10));
    wait_idle(bc);
    chk("R8 nvalid set", {63'h0, status[4]}, 64'h1);
    chk("R7 pulled-up data", {48'h0, status[31:16]}, {48'h0, 16'hFFFF});
    issue(cmd_word(16'h0102, 5'd4, 5'd0, 2'b01));
    chk("R8 start clears", {63'h0, status[4]}, 64'h0);
    wait_idle(bc);
  endtask

  task automatic t_both_bits();
    int bc;
    phy_on = 1'b1; phy_val = 16'h0F0F;
    issue(cmd_word(16'hBEEF, 5'd6, 5'd1, 2'b11));
    wait_idle(bc);
    chk("R2 both bits read opcode", {62'h0, cap_word()[29:28]}, 64'h2);
    chk("R2 both bits result", {48'h0, status[31:16]}, {48'h0, 16'h0F0F});
  endtask

  task automatic t_no_op();
    issue(cmd_word(16'h4242, 5'd12, 5'd13, 2'b00));
    chk("R2 no-op not busy", {63'h0, status[3]}, 64'h0);
    repeat (4*HALF) @(negedge clk);
    chk("R2 no-op no mdc", 64'(rise_cnt), 64'h0);
    chk("R2 fields loaded", {32'h0, status}, {32'h0, 16'h4242, 5'd12, 5'd13, 6'h0});
  endtask

  task automatic t_busy_ignore();
    int bc;
    issue(cmd_word(16'h3C3C, 5'd21, 5'd7, 2'b01));
    repeat (40) @(negedge clk);
    we = 1'b1; wdata = cmd_word(16'hFFFF, 5'd2, 5'd2, 2'b10);
    @(negedge clk); we = 1'b0;
    wait_idle(bc);
    chk("R9 frame unchanged", cap_word(), {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd21, 5'd7, 2'b10, 16'h3C3C});
    chk("R9 fields unchanged", {32'h0, status}, {32'h0, 16'h3C3C, 5'd21, 5'd7, 6'h0});
    chk("R9 busy length", 64'(bc + 41), 64'(128*HALF));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write();
    t_read_present();
    t_read_absent();
    t_both_bits();
    t_no_op();
    t_busy_ignore();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule